// File: doc/BRIEF.md
# Floating-Point Register Renamer

This block maps the logical floating-point registers used by micro-ops onto a larger pool of physical registers. The pool is large enough that every micro-op in flight can hold its own destination. Up to three micro-ops arrive together as one group. Each valid lane gets a fresh physical destination from a free pool. Each of its two sources is translated through a speculative map, which holds the newest in-flight mapping of every logical register.

There are 44 logical registers: eight stack/MMX registers, eight microcode scratch registers and the 128-bit vector registers, each of which takes one entry. There are 120 physical registers. A second map, the committed map, changes only when a micro-op retires. A retire names the logical register and the physical tag that now holds its committed value. The physical register that the committed map pointed to before is displaced and goes back to the free pool.

A flush throws away all speculative state. The speculative map is reloaded from the committed map. The free pool is rebuilt so that it holds every physical register the committed map does not point to.

Top module: `fp_rename`

## Requirements
- R1: After reset, logical register i maps to physical register i in both maps, and physical registers 44 to 119 are free. With nothing pending, the first destination handed out is 44.
- R2: Each valid lane of an accepted group gets its own free physical destination. The lowest-numbered free registers are assigned to the valid lanes in lane order (lane 0 first), skipping invalid lanes. Lane k uses bit k of `ren_valid` and bits [k*6 +: 6] or [k*7 +: 7] of the packed lane buses.
- R3: A source with no older writer in its group gets the physical tag that the speculative map holds for that logical register.
- R4: A source that names the destination of an older valid lane in the same group gets that lane's new physical tag. When several older lanes write it, the youngest of them wins.
- R5: When several lanes of one accepted group write the same logical register, the speculative map keeps the tag of the highest-numbered lane.
- R6: `ren_ready` is low when fewer registers are free than the group has valid lanes. A group that is not accepted changes neither map nor the free pool.
- R7: A retire writes its tag into the committed map entry of its logical register. The physical register that entry held before becomes free and can be allocated from the next cycle on. A retire leaves the speculative map unchanged.
- R8: During a flush, `ren_ready` is low and no group is accepted. From the next cycle, the speculative map equals the committed map, and the free pool is exactly the set of physical registers the committed map does not point to.
- R9: A retire in the same cycle as a flush takes effect before the restore. The restored speculative map and the rebuilt free pool both include that retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard speculative state and restore from the committed map |
| ren_valid | input | 3 | Per-lane valid of the rename group |
| ren_src_a | input | 18 | First logical source per lane, 6 bits each |
| ren_src_b | input | 18 | Second logical source per lane, 6 bits each |
| ren_dst | input | 18 | Logical destination per lane, 6 bits each |
| ren_ready | output | 1 | The group is accepted this cycle if any lane is valid |
| ren_psrc_a | output | 21 | Physical tag of the first source per lane, 7 bits each |
| ren_psrc_b | output | 21 | Physical tag of the second source per lane, 7 bits each |
| ren_pdst | output | 21 | Newly assigned physical destination per lane, 7 bits each |
| ret_valid | input | 1 | A micro-op retires this cycle |
| ret_lidx | input | 6 | Logical destination of the retiring micro-op |
| ret_ptag | input | 7 | Physical tag holding the retiring value |

## Verification
Two functions can land in the same cycle: a retire together with a flush, and a rename group offered during a flush. The bench retires logical register 3 onto tag 46 in the same cycle as a flush. It then checks that the next group reads 46 for source 3, and that it is handed both the old committed register 3 and the earlier-displaced register 1 as fresh destinations. The bench also offers a full group during a flush. It requires `ren_ready` to be low in that cycle, and it shows through the tags of the next group that nothing was allocated.

// File: rtl/fpren_pkg.sv
package fpren_pkg;
    localparam int NLOG  = 44;
    localparam int NPHYS = 120;
    localparam int LANES = 3;
    localparam int LW    = $clog2(NLOG);
    localparam int TW    = $clog2(NPHYS);
    localparam int CW    = $clog2(NPHYS + 1);
    localparam int SW    = $clog2(LANES + 1);

    typedef logic [LW-1:0] lidx_t;
    typedef logic [TW-1:0] ptag_t;
    typedef logic [NLOG-1:0][TW-1:0] map_t;
    typedef logic [NPHYS-1:0] pool_t;

    typedef struct packed {
        logic  vld;
        lidx_t src_a;
        lidx_t src_b;
        lidx_t dst;
    } req_t;

    typedef struct packed {
        logic  vld;
        lidx_t lidx;
        ptag_t ptag;
    } commit_t;

    function automatic map_t identity_map();
        map_t m;
        for (int i = 0; i < NLOG; i++) m[i] = ptag_t'(i);
        return m;
    endfunction

    function automatic pool_t unpointed(map_t m);
        pool_t v;
        v = '1;
        for (int i = 0; i < NLOG; i++) v[m[i]] = 1'b0;
        return v;
    endfunction
endpackage

// File: rtl/fpren_commit_map.sv
module fpren_commit_map
    import fpren_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  commit_t ret,
    output map_t    map_q,
    output map_t    map_next,
    output ptag_t   displaced
);
    always_comb begin
        map_next  = map_q;
        displaced = map_q[ret.lidx];
        if (ret.vld) map_next[ret.lidx] = ret.ptag;
    end

    always_ff @(posedge clk) begin
        if (rst) map_q <= identity_map();
        else     map_q <= map_next;
    end
endmodule

// File: rtl/fpren_spec_map.sv
module fpren_spec_map
    import fpren_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  map_t             restore,
    input  logic [LANES-1:0] wr_en,
    input  lidx_t            wr_idx [LANES],
    input  ptag_t            wr_tag [LANES],
    output map_t             map_q
);
    map_t map_d;

    always_comb begin
        map_d = map_q;
        if (flush) begin
            map_d = restore;
        end else begin
            for (int k = 0; k < LANES; k++)
                if (wr_en[k]) map_d[wr_idx[k]] = wr_tag[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) map_q <= identity_map();
        else     map_q <= map_d;
    end
endmodule

// File: rtl/fpren_free_pool.sv
module fpren_free_pool
    import fpren_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  pool_t            rebuild,
    input  logic [LANES-1:0] take_en,
    input  ptag_t            take_tag [LANES],
    input  logic             give_en,
    input  ptag_t            give_tag,
    output ptag_t            pick [LANES],
    output logic [CW-1:0]    free_cnt,
    output pool_t            free_q
);
    pool_t free_d;
    pool_t scan;

    always_comb begin
        scan = free_q;
        for (int k = 0; k < LANES; k++) begin
            pick[k] = '0;
            for (int i = NPHYS - 1; i >= 0; i--)
                if (scan[i]) pick[k] = ptag_t'(i);
            if (scan[pick[k]]) scan[pick[k]] = 1'b0;
        end
    end

    assign free_cnt = CW'($countones(free_q));

    always_comb begin
        free_d = free_q;
        if (flush) begin
            free_d = rebuild;
        end else begin
            for (int k = 0; k < LANES; k++)
                if (take_en[k]) free_d[take_tag[k]] = 1'b0;
            if (give_en) free_d[give_tag] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) free_q <= unpointed(identity_map());
        else     free_q <= free_d;
    end
endmodule

// File: rtl/fp_rename.sv
module fp_rename
    import fpren_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic [LANES-1:0]    ren_valid,
    input  logic [LANES*LW-1:0] ren_src_a,
    input  logic [LANES*LW-1:0] ren_src_b,
    input  logic [LANES*LW-1:0] ren_dst,
    output logic                ren_ready,
    output logic [LANES*TW-1:0] ren_psrc_a,
    output logic [LANES*TW-1:0] ren_psrc_b,
    output logic [LANES*TW-1:0] ren_pdst,
    input  logic                ret_valid,
    input  logic [LW-1:0]       ret_lidx,
    input  logic [TW-1:0]       ret_ptag
);
    req_t             req   [LANES];
    ptag_t            pdst  [LANES];
    ptag_t            psa   [LANES];
    ptag_t            psb   [LANES];
    lidx_t            widx  [LANES];
    ptag_t            pick  [LANES];
    logic [SW-1:0]    slot  [LANES];
    logic [CW-1:0]    need;
    logic [CW-1:0]    free_cnt;
    logic             accept;
    logic [LANES-1:0] take_en;
    commit_t          ret;
    map_t             arch_q, arch_next, spec_q;
    ptag_t            displaced;
    pool_t            free_q;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign req[k].vld   = ren_valid[k];
        assign req[k].src_a = ren_src_a[k*LW +: LW];
        assign req[k].src_b = ren_src_b[k*LW +: LW];
        assign req[k].dst   = ren_dst[k*LW +: LW];
        assign widx[k]      = req[k].dst;
        assign ren_pdst[k*TW +: TW]   = pdst[k];
        assign ren_psrc_a[k*TW +: TW] = psa[k];
        assign ren_psrc_b[k*TW +: TW] = psb[k];
    end

    // Compact the valid lanes onto consecutive free-pool picks.
    always_comb begin
        need = '0;
        for (int k = 0; k < LANES; k++) begin
            slot[k] = SW'(need);
            if (req[k].vld) need = need + 1'b1;
        end
    end

    always_comb begin
        for (int k = 0; k < LANES; k++) pdst[k] = pick[slot[k]];
    end

    // Source lookup with forwarding from older lanes of the same group.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            psa[k] = spec_q[req[k].src_a];
            psb[k] = spec_q[req[k].src_b];
            for (int j = 0; j < k; j++) begin
                if (req[j].vld && req[j].dst == req[k].src_a) psa[k] = pdst[j];
                if (req[j].vld && req[j].dst == req[k].src_b) psb[k] = pdst[j];
            end
        end
    end

    assign ren_ready = !flush && (free_cnt >= need);
    assign accept    = ren_ready && (|ren_valid);
    assign take_en   = ren_valid & {LANES{accept}};

    assign ret.vld  = ret_valid;
    assign ret.lidx = ret_lidx;
    assign ret.ptag = ret_ptag;

    fpren_commit_map i_commit (
        .clk       (clk),
        .rst       (rst),
        .ret       (ret),
        .map_q     (arch_q),
        .map_next  (arch_next),
        .displaced (displaced)
    );

    fpren_spec_map i_spec (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .restore (arch_next),
        .wr_en   (take_en),
        .wr_idx  (widx),
        .wr_tag  (pdst),
        .map_q   (spec_q)
    );

    fpren_free_pool i_pool (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .rebuild  (unpointed(arch_next)),
        .take_en  (take_en),
        .take_tag (pdst),
        .give_en  (ret_valid),
        .give_tag (displaced),
        .pick     (pick),
        .free_cnt (free_cnt),
        .free_q   (free_q)
    );
endmodule

// File: rtl/fp_rename_chk.sv
module fp_rename_chk
    import fpren_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                flush,
    input logic [LANES-1:0]    ren_valid,
    input logic [LANES*LW-1:0] ren_dst,
    input logic                ren_ready,
    input logic [LANES*TW-1:0] ren_pdst,
    input logic                accept,
    input logic                ret_valid,
    input logic [LW-1:0]       ret_lidx,
    input logic [TW-1:0]       ret_ptag,
    input pool_t               free_q,
    input map_t                spec_q,
    input map_t                arch_q
);
    localparam int TOP = LANES - 1;

    AST_FLUSH_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        flush |-> !ren_ready); // R8

    AST_STALL_WHEN_SHORT: assert property (@(posedge clk) disable iff (rst)
        ($countones(ren_valid) > $countones(free_q)) |-> !ren_ready); // R6

    for (genvar i = 0; i < LANES; i++) begin : g_free
        AST_PDST_WAS_FREE: assert property (@(posedge clk) disable iff (rst)
            (accept && ren_valid[i]) |-> free_q[ren_pdst[i*TW +: TW]]); // R2
        for (genvar j = i + 1; j < LANES; j++) begin : g_pair
            AST_PDST_UNIQUE: assert property (@(posedge clk) disable iff (rst)
                (accept && ren_valid[i] && ren_valid[j])
                |-> ren_pdst[i*TW +: TW] != ren_pdst[j*TW +: TW]); // R2
        end
    end

    AST_LAST_LANE_WINS: assert property (@(posedge clk) disable iff (rst)
        (accept && ren_valid[TOP])
        |=> spec_q[$past(ren_dst[TOP*LW +: LW])] == $past(ren_pdst[TOP*TW +: TW])); // R5

    AST_RETIRE_COMMIT: assert property (@(posedge clk) disable iff (rst)
        ret_valid |=> arch_q[$past(ret_lidx)] == $past(ret_ptag)); // R7

    AST_FLUSH_RESTORE: assert property (@(posedge clk) disable iff (rst)
        flush |=> spec_q == arch_q); // R8

    AST_FLUSH_POOL: assert property (@(posedge clk) disable iff (rst)
        flush |=> $countones(free_q) == NPHYS - NLOG); // R8

    AST_FLUSH_RETIRE: assert property (@(posedge clk) disable iff (rst)
        (flush && ret_valid) |=> spec_q[$past(ret_lidx)] == $past(ret_ptag)); // R9
endmodule

bind fp_rename fp_rename_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .ren_valid (ren_valid),
    .ren_dst   (ren_dst),
    .ren_ready (ren_ready),
    .ren_pdst  (ren_pdst),
    .accept    (accept),
    .ret_valid (ret_valid),
    .ret_lidx  (ret_lidx),
    .ret_ptag  (ret_ptag),
    .free_q    (free_q),
    .spec_q    (spec_q),
    .arch_q    (arch_q)
);

// File: tb/test_fp_rename.sv
module test_fp_rename;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct packed {
        logic [2:0]  v;
        logic [17:0] a;
        logic [17:0] b;
        logic [17:0] d;
        logic [20:0] ea;
        logic [20:0] eb;
        logic [20:0] ep;
    } row_t;

    // Lanes packed as {lane2, lane1, lane0}.
    localparam row_t TBL [5] = '{
        '{3'b111, {6'd3, 6'd2, 6'd1}, {6'd2, 6'd1, 6'd0}, {6'd3, 6'd2, 6'd1},
          {7'd3, 7'd2, 7'd1}, {7'd45, 7'd44, 7'd0}, {7'd46, 7'd45, 7'd44}},
        '{3'b101, {6'd5, 6'd9, 6'd1}, {6'd3, 6'd3, 6'd3}, {6'd5, 6'd0, 6'd5},
          {7'd47, 7'd0, 7'd44}, {7'd46, 7'd0, 7'd46}, {7'd48, 7'd0, 7'd47}},
        '{3'b100, {6'd5, 6'd0, 6'd0}, {6'd2, 6'd0, 6'd0}, {6'd7, 6'd0, 6'd0},
          {7'd48, 7'd0, 7'd0}, {7'd45, 7'd0, 7'd0}, {7'd49, 7'd0, 7'd0}},
        '{3'b000, 18'd0, 18'd0, 18'd0, 21'd0, 21'd0, 21'd0},
        '{3'b010, {6'd0, 6'd7, 6'd0}, {6'd0, 6'd5, 6'd0}, {6'd0, 6'd7, 6'd0},
          {7'd0, 7'd49, 7'd0}, {7'd0, 7'd48, 7'd0}, {7'd0, 7'd50, 7'd0}}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        flush;
    logic [2:0]  ren_valid;
    logic [17:0] ren_src_a, ren_src_b, ren_dst;
    logic        ren_ready;
    logic [20:0] ren_psrc_a, ren_psrc_b, ren_pdst;
    logic        ret_valid;
    logic [5:0]  ret_lidx;
    logic [6:0]  ret_ptag;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_rename i_fp_rename (
        .clk(clk), .rst(rst), .flush(flush),
        .ren_valid(ren_valid), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_dst(ren_dst), .ren_ready(ren_ready), .ren_psrc_a(ren_psrc_a),
        .ren_psrc_b(ren_psrc_b), .ren_pdst(ren_pdst),
        .ret_valid(ret_valid), .ret_lidx(ret_lidx), .ret_ptag(ret_ptag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] v, input logic [17:0] a, input logic [17:0] b,
                         input logic [17:0] d, input logic fl, input logic rv,
                         input logic [5:0] rl, input logic [6:0] rp);
        @(negedge clk);
        ren_valid = v; ren_src_a = a; ren_src_b = b; ren_dst = d;
        flush = fl; ret_valid = rv; ret_lidx = rl; ret_ptag = rp;
        #1;
    endtask

    function automatic int lane(input logic [20:0] bus, input int k);
        return int'(bus[k*7 +: 7]);
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; flush = 1'b0; ren_valid = '0; ren_src_a = '0; ren_src_b = '0;
        ren_dst = '0; ret_valid = 1'b0; ret_lidx = '0; ret_ptag = '0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: identity mapping out of reset
        drive(3'b000, {6'd20, 6'd43, 6'd0}, {6'd1, 6'd2, 6'd3}, 18'd0, 0, 0, 0, 0);
        check("R1 ready", ren_ready, 1);
        check("R1 src a0", lane(ren_psrc_a, 0), 0);
        check("R1 src a1", lane(ren_psrc_a, 1), 43);
        check("R1 src a2", lane(ren_psrc_a, 2), 20);
        check("R1 src b2", lane(ren_psrc_b, 2), 1);

        // Table of rename groups: R1 R2 R3 R4 R5 R6
        for (int r = 0; r < 5; r++) begin
            drive(TBL[r].v, TBL[r].a, TBL[r].b, TBL[r].d, 0, 0, 0, 0);
            check("R6 ready", ren_ready, 1);
            for (int k = 0; k < 3; k++) begin
                if (TBL[r].v[k]) begin
                    check("R3 R4 R5 src a", lane(ren_psrc_a, k), lane(TBL[r].ea, k));
                    check("R3 R4 src b",    lane(ren_psrc_b, k), lane(TBL[r].eb, k));
                    check("R2 pdst",        lane(ren_pdst, k),   lane(TBL[r].ep, k));
                end
            end
        end

        // R7: retire logical 1 onto 44; old register 1 becomes free
        drive(3'b000, 18'd0, 18'd0, 18'd0, 0, 1, 6'd1, 7'd44);
        drive(3'b001, {12'd0, 6'd1}, 18'd0, {12'd0, 6'd10}, 0, 0, 0, 0);
        check("R7 spec untouched", lane(ren_psrc_a, 0), 44);
        check("R7 displaced reused", lane(ren_pdst, 0), 1);

        // R8: flush blocks a group, then restores
        drive(3'b111, 18'd0, 18'd0, {6'd3, 6'd3, 6'd3}, 1, 0, 0, 0);
        check("R8 ready low in flush", ren_ready, 0);
        drive(3'b111, {6'd10, 6'd7, 6'd1}, 18'd0, {6'd22, 6'd21, 6'd20}, 0, 0, 0, 0);
        check("R8 restored a0", lane(ren_psrc_a, 0), 44);
        check("R8 restored a1", lane(ren_psrc_a, 1), 7);
        check("R8 restored a2", lane(ren_psrc_a, 2), 10);
        check("R8 rebuilt p0", lane(ren_pdst, 0), 1);
        check("R8 rebuilt p1", lane(ren_pdst, 1), 45);
        check("R8 rebuilt p2", lane(ren_pdst, 2), 46);

        // R9: retire in the flush cycle
        drive(3'b000, 18'd0, 18'd0, 18'd0, 1, 1, 6'd3, 7'd46);
        drive(3'b111, {6'd0, 6'd1, 6'd3}, 18'd0, {6'd32, 6'd31, 6'd30}, 0, 0, 0, 0);
        check("R9 src a0", lane(ren_psrc_a, 0), 46);
        check("R9 src a1", lane(ren_psrc_a, 1), 44);
        check("R9 src a2", lane(ren_psrc_a, 2), 0);
        check("R9 p0", lane(ren_pdst, 0), 1);
        check("R9 p1", lane(ren_pdst, 1), 3);
        check("R9 p2", lane(ren_pdst, 2), 45);

        // R6: drain 47..118, leaving only 119 free
        for (int g = 0; g < 24; g++) begin
            drive(3'b111, 18'd0, 18'd0, {6'd40, 6'd40, 6'd40}, 0, 0, 0, 0);
            check("R2 drain p0", lane(ren_pdst, 0), 47 + 3*g);
            check("R2 drain p2", lane(ren_pdst, 2), 49 + 3*g);
        end
        drive(3'b011, 18'd0, 18'd0, {6'd0, 6'd41, 6'd41}, 0, 0, 0, 0);
        check("R6 stall two lanes", ren_ready, 0);
        drive(3'b001, 18'd0, 18'd0, {12'd0, 6'd41}, 0, 0, 0, 0);
        check("R6 one lane ready", ren_ready, 1);
        check("R6 stalled group took nothing", lane(ren_pdst, 0), 119);
        drive(3'b001, 18'd0, 18'd0, {12'd0, 6'd42}, 0, 0, 0, 0);
        check("R6 empty pool stalls", ren_ready, 0);
        drive(3'b000, 18'd0, 18'd0, 18'd0, 0, 0, 0, 0);
        check("R6 empty group ready", ren_ready, 1);

        // R1: reset again
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        drive(3'b000, {6'd5, 6'd43, 6'd1}, 18'd0, 18'd0, 0, 0, 0, 0);
        check("R1 reset src a0", lane(ren_psrc_a, 0), 1);
        check("R1 reset src a1", lane(ren_psrc_a, 1), 43);
        drive(3'b001, 18'd0, 18'd0, {12'd0, 6'd2}, 0, 0, 0, 0);
        check("R1 first alloc", lane(ren_pdst, 0), 44);
        drive(3'b000, 18'd0, 18'd0, 18'd0, 0, 0, 0, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule